// File: doc/BRIEF.md
# TDM Slot Assigner with Bypass

This block serves one side of a serial time-division-multiplexed voice port. A bit clock and an 8 kHz frame pulse arrive on the bit-clock pins. Both are sampled on a faster system clock, and the block keeps a bit counter for the frame. The input slot and the output slot are each programmed with a 6-bit number. During the input slot the block shifts in the serial line on falling bit-clock edges, most significant bit first. It then hands the finished word to a transcoder over a one-cycle request. The transcoder answers with an acknowledge and a result word.

The result, or in bypass the raw input word, is held and sent in the output slot of the next frame. Output bits change on rising bit-clock edges. Outside the output slot the output enable is low, so the line is released for other devices. The slot width follows the coding direction. In compress mode input slots are 8 bits and output slots are 4 bits. In expand mode input slots are 4 bits and output slots are 8 bits. Bypass copies words unchanged using a single width on both sides: 8 bits when compressing and 4 bits when expanding. An idle setting releases the output and stops capture.

Top module: `tsa_port`

## Requirements
- R1: After reset `sdout_en`, `sdout` and `xc_req` are low.
- R2: Bit 0 of a frame is the first rising bit-clock edge after the frame pulse is seen high. Slot n of width w covers bits n*w to n*w+w-1.
- R3: In the input slot the line is sampled on each falling edge, MSB first. The slot is 8 bits when `cfg_compress`=1 and 4 bits when it is 0. A 4-bit word sits in bits 3:0 of `xc_word` with bits 7:4 zero. A finished word raises `xc_req` for exactly one cycle.
- R4: Outside bypass the output slot is 4 bits when `cfg_compress`=1 and 8 bits when it is 0. The block sends the low 4 or all 8 bits of the held word, MSB first, one bit per bit period.
- R5: `sdout_en` is high for exactly the bit periods of the output slot. `sdout` is 0 whenever `sdout_en` is low.
- R6: A word held during frame f is sent in frame f+1. Frames before the first capture send zero.
- R7: A slot number at or beyond 256 divided by the slot width never matches, so nothing is captured or driven on that side.
- R8: With `cfg_idle`=1 the output enable stays low, no word is captured and no request is made.
- R9: With `cfg_bypass`=1 and `cfg_idle`=0 the captured word is held unchanged without a request. Both slots use 8 bits when `cfg_compress`=1 and 4 bits when it is 0.
- R10: Before the first frame pulse nothing is captured or driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame pulse, high for one bit period before bit 0 |
| sdin | input | 1 | Serial data in |
| cfg_compress | input | 1 | 1 = compress (8-bit in, 4-bit out), 0 = expand |
| cfg_idle | input | 1 | 1 = side idle, output released |
| cfg_bypass | input | 1 | 1 = copy input word to output unchanged |
| cfg_in_slot | input | 6 | Input slot number |
| cfg_out_slot | input | 6 | Output slot number |
| xc_req | output | 1 | One-cycle pulse: captured word ready |
| xc_word | output | 8 | Captured word |
| xc_ack | input | 1 | Transcoder result valid |
| xc_result | input | 8 | Transcoder result word |
| sdout | output | 1 | Serial data out |
| sdout_en | output | 1 | Output drive enable (low = tri-state) |

## Verification
Capture on a falling edge and drive on a rising edge can fall in the same bit period. This happens when the input and output slots overlap. The directed frame with both slots at 0 provokes it, and so do random frames that share slot numbers. In each bit period the bench compares the driven bit with the word held from the previous frame. After each frame it compares the requested word with the bits it shifted in. The two functions are judged independently, so one overwriting the other would show up in either comparison.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    typedef enum logic {
        SZ_NARROW = 1'b0,
        SZ_WIDE   = 1'b1
    } slot_size_e;

    function automatic slot_size_e in_size(input logic compress);
        return compress ? SZ_WIDE : SZ_NARROW;
    endfunction

    function automatic slot_size_e out_size(input logic compress, input logic bypass);
        return (bypass ? compress : ~compress) ? SZ_WIDE : SZ_NARROW;
    endfunction
endpackage

// File: rtl/tsa_edge_sync.sv
module tsa_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fsync_i,
    input  logic sdin_i,
    output logic bit_rise,
    output logic bit_fall,
    output logic frame_mark,
    output logic sd_bit
);
    typedef struct packed {
        logic bclk_s;
        logic bclk_p;
        logic fs_s;
        logic fs_p;
        logic sd_s;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.bclk_s = bclk_i;
        sync_d.bclk_p = sync_q.bclk_s;
        sync_d.fs_s   = fsync_i;
        sync_d.fs_p   = sync_q.fs_s;
        sync_d.sd_s   = sdin_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign bit_rise   = sync_q.bclk_s & ~sync_q.bclk_p;
    assign bit_fall   = ~sync_q.bclk_s & sync_q.bclk_p;
    assign frame_mark = sync_q.fs_s & ~sync_q.fs_p;
    assign sd_bit     = sync_q.sd_s;
endmodule

// File: rtl/tsa_slot_hit.sv
module tsa_slot_hit #(
    parameter int CNT_W      = 9,
    parameter int SLOT_W     = 6,
    parameter int FRAME_BITS = 256,
    parameter int NARROW_W   = 4,
    parameter int WIDE_W     = 8,
    localparam int POS_W     = $clog2(WIDE_W)
) (
    input  logic [CNT_W-1:0]  cnt,
    input  tsa_pkg::slot_size_e size,
    input  logic [SLOT_W-1:0] slot,
    output logic              hit,
    output logic [POS_W-1:0]  pos
);
    localparam int NSH = $clog2(NARROW_W);
    localparam int WSH = $clog2(WIDE_W);

    logic [CNT_W-1:0] idx;
    logic             in_frame;

    always_comb begin
        in_frame = cnt < CNT_W'(FRAME_BITS);
        if (size == tsa_pkg::SZ_WIDE) begin
            idx = cnt >> WSH;
            pos = POS_W'(cnt & CNT_W'(WIDE_W - 1));
        end else begin
            idx = cnt >> NSH;
            pos = POS_W'(cnt & CNT_W'(NARROW_W - 1));
        end
        hit = in_frame && (idx == CNT_W'(slot));
    end
endmodule

// File: rtl/tsa_port.sv
module tsa_port #(
    parameter int FRAME_BITS = 256,
    parameter int SLOT_W     = 6,
    parameter int NARROW_W   = 4,
    parameter int WIDE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              sdin,
    input  logic              cfg_compress,
    input  logic              cfg_idle,
    input  logic              cfg_bypass,
    input  logic [SLOT_W-1:0] cfg_in_slot,
    input  logic [SLOT_W-1:0] cfg_out_slot,
    output logic              xc_req,
    output logic [WIDE_W-1:0] xc_word,
    input  logic              xc_ack,
    input  logic [WIDE_W-1:0] xc_result,
    output logic              sdout,
    output logic              sdout_en
);
    import tsa_pkg::*;

    localparam int CNT_W = $clog2(FRAME_BITS) + 1;
    localparam int POS_W = $clog2(WIDE_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              run;
        logic              fs_pend;
        logic [WIDE_W-1:0] shreg;
        logic              req;
        logic [WIDE_W-1:0] req_word;
        logic [WIDE_W-1:0] pend;
        logic [WIDE_W-1:0] tx;
        logic              oe;
        logic              dout;
    } state_t;

    state_t st_d, st_q;

    logic bit_rise, bit_fall, frame_mark, sd_bit;
    logic [CNT_W-1:0] cnt_nx;
    logic             run_nx;
    logic             in_hit, out_hit;
    logic [POS_W-1:0] in_pos, out_pos, in_msb, out_msb, out_bit;
    slot_size_e       in_sz, out_sz;
    logic [WIDE_W-1:0] cap_word;

    tsa_edge_sync i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk),
        .fsync_i   (fsync),
        .sdin_i    (sdin),
        .bit_rise  (bit_rise),
        .bit_fall  (bit_fall),
        .frame_mark(frame_mark),
        .sd_bit    (sd_bit)
    );

    always_comb begin
        in_sz  = in_size(cfg_compress);
        out_sz = out_size(cfg_compress, cfg_bypass);
        in_msb  = (in_sz  == SZ_WIDE) ? POS_W'(WIDE_W - 1) : POS_W'(NARROW_W - 1);
        out_msb = (out_sz == SZ_WIDE) ? POS_W'(WIDE_W - 1) : POS_W'(NARROW_W - 1);
        if (st_q.fs_pend)                          cnt_nx = '0;
        else if (st_q.cnt == CNT_W'(FRAME_BITS))   cnt_nx = st_q.cnt;
        else                                       cnt_nx = st_q.cnt + 1'b1;
        run_nx = st_q.run | st_q.fs_pend;
    end

    // input slot decode uses the count of the current bit period,
    // output slot decode the count that starts at this rising edge
    tsa_slot_hit #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .FRAME_BITS(FRAME_BITS),
                   .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) i_in_hit (
        .cnt (st_q.cnt),
        .size(in_sz),
        .slot(cfg_in_slot),
        .hit (in_hit),
        .pos (in_pos)
    );

    tsa_slot_hit #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .FRAME_BITS(FRAME_BITS),
                   .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) i_out_hit (
        .cnt (cnt_nx),
        .size(out_sz),
        .slot(cfg_out_slot),
        .hit (out_hit),
        .pos (out_pos)
    );

    assign out_bit = out_msb - out_pos;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        cap_word = '0;

        if (bit_rise) begin
            st_d.cnt = cnt_nx;
            st_d.run = run_nx;
            if (st_q.fs_pend) begin
                st_d.fs_pend = 1'b0;
                st_d.tx      = st_q.pend;
            end
            st_d.oe   = run_nx && out_hit;
            st_d.dout = st_d.oe && st_d.tx[out_bit];
        end

        if (frame_mark) st_d.fs_pend = 1'b1;

        if (xc_ack && !cfg_bypass) st_d.pend = xc_result;

        if (bit_fall && st_q.run && !cfg_idle && in_hit) begin
            st_d.shreg = {st_q.shreg[WIDE_W-2:0], sd_bit};
            if (in_pos == in_msb) begin
                if (in_sz == SZ_WIDE) cap_word = st_d.shreg;
                else cap_word = {{(WIDE_W-NARROW_W){1'b0}}, st_d.shreg[NARROW_W-1:0]};
                if (cfg_bypass) begin
                    st_d.pend = cap_word;
                end else begin
                    st_d.req      = 1'b1;
                    st_d.req_word = cap_word;
                end
            end
        end

        if (cfg_idle) begin
            st_d.oe   = 1'b0;
            st_d.dout = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CNT_W'(FRAME_BITS);
        end else begin
            st_q <= st_d;
        end
    end

    assign xc_req   = st_q.req;
    assign xc_word  = st_q.req_word;
    assign sdout    = st_q.dout;
    assign sdout_en = st_q.oe;
endmodule

// File: rtl/tsa_port_chk.sv
module tsa_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_idle,
    input logic cfg_bypass,
    input logic xc_req,
    input logic sdout,
    input logic sdout_en
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sdout_en && !sdout && !xc_req));

    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xc_req |=> !xc_req);

    assert_data_low_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sdout_en |-> !sdout);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idle && $past(cfg_idle)) |-> (!sdout_en && !xc_req));

    assert_bypass_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bypass && !cfg_idle && $past(cfg_bypass) && !$past(cfg_idle)) |-> !xc_req);
endmodule

bind tsa_port tsa_port_chk i_tsa_port_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_idle  (cfg_idle),
    .cfg_bypass(cfg_bypass),
    .xc_req    (xc_req),
    .sdout     (sdout),
    .sdout_en  (sdout_en)
);

// File: tb/test_tsa_port.sv
module test_tsa_port;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       bclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
    logic       cfg_compress = 1'b1, cfg_idle = 1'b0, cfg_bypass = 1'b0;
    logic [5:0] cfg_in_slot = '0, cfg_out_slot = '0;
    logic       xc_req, xc_ack = 1'b0;
    logic [7:0] xc_word, xc_result = '0;
    logic       sdout, sdout_en;

    int n_chk = 0, n_fail = 0, n_req = 0;
    logic [7:0] last_req = '0;
    logic [7:0] pend_exp = '0;

    tsa_port i_tsa_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
        .cfg_compress(cfg_compress), .cfg_idle(cfg_idle), .cfg_bypass(cfg_bypass),
        .cfg_in_slot(cfg_in_slot), .cfg_out_slot(cfg_out_slot),
        .xc_req(xc_req), .xc_word(xc_word), .xc_ack(xc_ack), .xc_result(xc_result),
        .sdout(sdout), .sdout_en(sdout_en)
    );

    function automatic logic [7:0] xform(input logic [7:0] w);
        return {w[3:0], w[7:4]} ^ 8'hA5;
    endfunction

    // transcoder stand-in: answers one cycle after a request
    always @(posedge clk) begin
        xc_ack    <= xc_req;
        xc_result <= xform(xc_word);
        if (xc_req) begin
            n_req    = n_req + 1;
            last_req = xc_word;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one bit period with no frame running; output must stay released
    task automatic idle_period(input bit fs);
        @(negedge clk);
        bclk = 1'b1; sdin = 1'($urandom); fsync = fs;
        wait_neg(5);
        chk(sdout_en == 1'b0 && sdout == 1'b0, "R10 no drive before sync",
            int'({sdout_en, sdout}), 0);
        @(negedge clk);
        bclk = 1'b0;
        wait_neg(5);
    endtask

    task automatic run_frame(input bit comp, input bit byp, input bit idl,
                             input int is, input int os, input string tag);
        logic [255:0] bits;
        logic [7:0]   tx, word;
        int iw, ow, k, b;
        bit capt, ex_oe, ex_d;
        for (int i = 0; i < 256; i++) bits[i] = 1'($urandom);
        iw   = comp ? 8 : 4;
        ow   = byp ? iw : (comp ? 4 : 8);
        tx   = pend_exp;
        capt = !idl && (is < 256 / iw);
        word = '0;
        if (capt) for (b = 0; b < iw; b++) word = {word[6:0], bits[is*iw + b]};
        n_req = 0;
        for (k = 0; k < 256; k++) begin
            @(negedge clk);
            if (k == 0) begin
                cfg_compress = comp; cfg_bypass = byp; cfg_idle = idl;
                cfg_in_slot = 6'(is); cfg_out_slot = 6'(os);
            end
            bclk = 1'b1; sdin = bits[k]; fsync = (k == 255);
            wait_neg(5);
            ex_oe = !idl && (k / ow == os);
            ex_d  = ex_oe && tx[ow - 1 - (k % ow)];
            chk({sdout_en, sdout} == {ex_oe, ex_d}, tag,
                int'({sdout_en, sdout}), int'({ex_oe, ex_d}));
            @(negedge clk);
            bclk = 1'b0;
            wait_neg(5);
        end
        // R3 / R8 / R9: one request with the shifted word, or none
        chk(n_req == ((capt && !byp) ? 1 : 0), "R3 request count", n_req,
            (capt && !byp) ? 1 : 0);
        if (capt && !byp) chk(last_req == word, "R3 captured word", int'(last_req), int'(word));
        if (capt) pend_exp = byp ? word : xform(word);
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_neg(4);
        rst_n = 1'b1;
        wait_neg(2);
        chk(sdout_en == 1'b0 && sdout == 1'b0 && xc_req == 1'b0, "R1 reset state",
            int'({sdout_en, sdout, xc_req}), 0);
        // R10: bit clock running without frame pulse
        n_req = 0;
        for (int i = 0; i < 20; i++) idle_period(1'b0);
        chk(n_req == 0, "R10 no capture before sync", n_req, 0);
        idle_period(1'b1);
        // R2 / R6: slot 0 both ways, first frame sends zero; capture and drive overlap
        run_frame(1'b1, 1'b0, 1'b0, 0, 0, "R2 R6 slot0 compress");
        run_frame(1'b1, 1'b0, 1'b0, 0, 0, "R6 R4 slot0 compress");
        // R4: expand, last slots
        run_frame(1'b0, 1'b0, 1'b0, 63, 31, "R4 R5 expand last slots");
        run_frame(1'b0, 1'b0, 1'b0, 10, 31, "R4 R5 expand");
        // R9: bypass both widths
        run_frame(1'b1, 1'b1, 1'b0, 31, 5, "R9 bypass wide");
        run_frame(1'b1, 1'b1, 1'b0, 3, 31, "R9 bypass wide");
        run_frame(1'b0, 1'b1, 1'b0, 63, 0, "R9 bypass narrow");
        run_frame(1'b0, 1'b1, 1'b0, 7, 63, "R9 bypass narrow");
        // R8: idle
        run_frame(1'b1, 1'b0, 1'b1, 2, 2, "R8 idle");
        run_frame(1'b1, 1'b0, 1'b0, 2, 2, "R8 after idle");
        // R7: out of range slots
        run_frame(1'b1, 1'b0, 1'b0, 40, 12, "R7 input out of range");
        run_frame(1'b0, 1'b0, 1'b0, 20, 40, "R7 output out of range");
        run_frame(1'b1, 1'b1, 1'b0, 50, 50, "R7 bypass out of range");
        // constrained random frames
        for (int f = 0; f < 20; f++) begin
            bit c, y, d;
            c = 1'($urandom);
            y = 1'($urandom_range(0, 3) == 0);
            d = 1'($urandom_range(0, 7) == 0);
            run_frame(c, y, d, int'($urandom_range(0, 63)), int'($urandom_range(0, 63)),
                      d ? "R8 random" : (y ? "R9 random" : "R4 R5 random"));
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule